// File: doc/BRIEF.md
# Suspend and wake-mode control register

This block is the power-management register slice of a network controller. A host writes a control word that holds a wake-enable bit, a wake-mode bit and a suspend request. From these bits and an external sleep pin, the block decides whether the controller listens for wake patterns. When the wake-mode bit is 1, the sleep pin is repurposed: it stops acting as a sleep request and acts as a second wake-enable source.

A suspend request goes to the datapath as a level signal. The suspend bit the host reads back is not the request. It is a separate suspended flag, which becomes 1 only after the datapath acknowledges that it is quiescent. The host therefore writes the request and polls until the bit reads 1. Clearing the bit, asserting stop or applying a reset ends suspend. The wake bits survive stop and are cleared only by a reset.

The block also gates the host's view of a ring-length register. An initialization sequencer loads this register with two 4-bit encoded lengths. The host may read it only while stop is active or the controller is suspended.

Top module: `pm_susp_ctl`

## Requirements
- R1: Hardware reset (`rst_n` low, released after two clock edges) and software reset (`soft_rst` sampled high at a clock edge) clear the wake-enable bit, the wake-mode bit, the suspend request and the suspended flag.
- R2: In the control word (`wr_sel`/`rd_sel` = 0), bit 0 is wake-enable and bit 1 is wake-mode. Both are written on every control write and read back at all times. Stop never changes them.
- R3: `wake_active` equals wake-mode AND (`sleep_pin` OR wake-enable).
- R4: `sleep_req` follows `sleep_pin` while wake-mode is 0 and is held at 0 while wake-mode is 1.
- R5: A control write with bit 4 set raises `spnd_req` at that clock edge when `stop` is 0. When `stop` is 1 the request is ignored and `spnd_req` stays 0.
- R6: Control-word bit 4 reads the suspended flag. The flag sets at the first edge where `spnd_req` is 1 and `spnd_ack` is 1, and it stays set while the request stays asserted.
- R7: A control write with bit 4 clear drops `spnd_req` at that edge. The suspended flag clears at the following edge.
- R8: While `stop` is 1, the suspend request and the suspended flag are cleared at each edge, whatever `spnd_ack` does.
- R9: A ring-length read (`rd_sel` = 1) returns the transmit length in bits 15:12 and the receive length in bits 11:8, with all other bits 0, while `stop` is 1 or the suspended flag is 1. At all other times it returns all zeros.
- R10: The ring-length fields change only when `ring_load` is high at a clock edge. Host writes to the ring register (`wr_sel` = 1) and both resets leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| soft_rst | input | 1 | Software reset, synchronous |
| stop | input | 1 | Stop command level |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 ring length |
| wr_data | input | 32 | Host write data |
| rd_sel | input | 1 | Read target: 0 control, 1 ring length |
| rd_data | output | 32 | Host read data (combinational) |
| sleep_pin | input | 1 | External sleep / wake-enable pin |
| wake_active | output | 1 | Wake-pattern listening mode active |
| sleep_req | output | 1 | Sleep request passed on when the pin is not repurposed |
| spnd_req | output | 1 | Suspend request to the datapath |
| spnd_ack | input | 1 | Datapath quiescent acknowledge |
| ring_load | input | 1 | Load strobe from the initialization sequencer |
| ring_tx_len | input | 4 | Transmit encoded ring length to load |
| ring_rx_len | input | 4 | Receive encoded ring length to load |

## Verification
Two events can land on the same clock edge: a host write that clears the suspend bit and a datapath acknowledge that would set the suspended flag. The bench provokes this by raising `spnd_ack` in the cycle it writes 0 to bit 4. The judgement is that the flag may show 1 for exactly one cycle and must be 0 on the edge after. A second collision drives `stop` high on the same edge as a suspend write. The request must stay low, and the wake bits written in that same write must still be taken. A behavioural model runs alongside the design and checks every output on every cycle.

// File: rtl/pm_susp_pkg.sv
package pm_susp_pkg;

  // Control word field positions
  localparam int unsigned EN_POS   = 0;
  localparam int unsigned MODE_POS = 1;
  localparam int unsigned SPND_POS = 4;

  // Ring-length word field positions (decoded by host software)
  localparam int unsigned RX_POS = 8;
  localparam int unsigned TX_POS = 12;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_RING = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic mode;
    logic en;
  } wake_cfg_t;

endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
  import pm_susp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      soft_rst,
  input  logic      cfg_we,
  input  wake_cfg_t cfg_wdata,
  input  logic      sleep_pin,
  output wake_cfg_t cfg_q,
  output logic      wake_active,
  output logic      sleep_req
);

  wake_cfg_t cfg_d;
  logic      cfg_ce;

  always_comb begin
    cfg_ce = soft_rst | cfg_we;
    cfg_d  = cfg_q;
    if (soft_rst)    cfg_d = '0;
    else if (cfg_we) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (cfg_ce) cfg_q <= cfg_d;
  end

  // Mode decode: with wake-mode set, the pin becomes a wake-enable source
  always_comb begin
    wake_active = cfg_q.mode & (sleep_pin | cfg_q.en);
    sleep_req   = sleep_pin & ~cfg_q.mode;
  end

  a_r1_soft_clears_cfg: assert property (@(posedge clk) disable iff (!rst_ni)
    soft_rst |=> (cfg_q == '0));

  a_r3_idle_without_mode: assert property (@(posedge clk) disable iff (!rst_ni)
    !cfg_q.mode |-> !wake_active);

  a_r3_pin_wakes: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_q.mode && sleep_pin) |-> wake_active);

  a_r4_pin_repurposed: assert property (@(posedge clk) disable iff (!rst_ni)
    cfg_q.mode |-> !sleep_req);

endmodule

// File: rtl/pm_susp_hs.sv
module pm_susp_hs (
  input  logic clk,
  input  logic rst_ni,
  input  logic soft_rst,
  input  logic stop,
  input  logic req_we,
  input  logic req_wval,
  input  logic ack,
  output logic req_q,
  output logic done_q
);

  logic req_d;
  logic done_d;

  always_comb begin
    if (soft_rst || stop) begin
      req_d  = 1'b0;
      done_d = 1'b0;
    end else begin
      req_d  = req_we ? req_wval : req_q;
      done_d = req_q & (done_q | ack);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      done_q <= done_d;
    end
  end

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    stop |=> (!req_q && !done_q));

  a_r5_stop_blocks_request: assert property (@(posedge clk) disable iff (!rst_ni)
    (stop && req_we && req_wval) |=> !req_q);

  a_r6_flag_needs_ack: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(ack) && $past(req_q)));

  a_r7_flag_follows_request: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_q |=> !done_q);

endmodule

// File: rtl/pm_ring_len.sv
module pm_ring_len
  import pm_susp_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [LEN_W-1:0]  tx_in,
  input  logic [LEN_W-1:0]  rx_in,
  input  logic              rd_allow,
  output logic [DATA_W-1:0] rd_word
);

  logic [LEN_W-1:0] tx_q;
  logic [LEN_W-1:0] rx_q;

  // No reset: the fields keep their contents across every reset
  always_ff @(posedge clk) begin
    if (load) begin
      tx_q <= tx_in;
      rx_q <= rx_in;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_allow) begin
      rd_word[TX_POS +: LEN_W] = tx_q;
      rd_word[RX_POS +: LEN_W] = rx_q;
    end
  end

  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !load |=> ($stable(tx_q) && $stable(rx_q)));

endmodule

// File: rtl/pm_susp_ctl.sv
module pm_susp_ctl
  import pm_susp_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned LEN_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sleep_pin,
  output logic              wake_active,
  output logic              sleep_req,
  output logic              spnd_req,
  input  logic              spnd_ack,
  input  logic              ring_load,
  input  logic [LEN_W-1:0]  ring_tx_len,
  input  logic [LEN_W-1:0]  ring_rx_len
);

  localparam int unsigned TOP_USED = TX_POS + LEN_W;

  logic             rst_int_n;
  logic             ctrl_we;
  wake_cfg_t        cfg_wdata;
  wake_cfg_t        cfg_q;
  logic             spnd_done;
  logic             ring_allow;
  logic [DATA_W-1:0] ring_word;
  logic [DATA_W-1:0] ctrl_word;
  logic             unused_wdata;

  initial begin
    if (DATA_W < TOP_USED) $error("DATA_W too narrow for ring fields");
  end

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  always_comb begin
    ctrl_we        = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    cfg_wdata.en   = wr_data[EN_POS];
    cfg_wdata.mode = wr_data[MODE_POS];
    unused_wdata   = ^wr_data;
  end

  pm_wake_ctl u_wake (
    .clk         (clk),
    .rst_ni      (rst_int_n),
    .soft_rst    (soft_rst),
    .cfg_we      (ctrl_we),
    .cfg_wdata   (cfg_wdata),
    .sleep_pin   (sleep_pin),
    .cfg_q       (cfg_q),
    .wake_active (wake_active),
    .sleep_req   (sleep_req)
  );

  pm_susp_hs u_susp (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .soft_rst (soft_rst),
    .stop     (stop),
    .req_we   (ctrl_we),
    .req_wval (wr_data[SPND_POS]),
    .ack      (spnd_ack),
    .req_q    (spnd_req),
    .done_q   (spnd_done)
  );

  assign ring_allow = stop | spnd_done;

  pm_ring_len #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ring (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .load     (ring_load),
    .tx_in    (ring_tx_len),
    .rx_in    (ring_rx_len),
    .rd_allow (ring_allow),
    .rd_word  (ring_word)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[EN_POS]   = cfg_q.en;
    ctrl_word[MODE_POS] = cfg_q.mode;
    ctrl_word[SPND_POS] = spnd_done;
    rd_data = (reg_sel_e'(rd_sel) == SEL_RING) ? ring_word : ctrl_word;
  end

  a_r2_stop_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop && !soft_rst && !ctrl_we) |=> $stable(cfg_q));

  a_r9_blocked_read: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_sel && !stop && !spnd_done) |-> (rd_data == '0));

endmodule

// File: tb/pm_susp_ctl_tb.sv
module pm_susp_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n, soft_rst, stop, wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        sleep_pin, wake_active, sleep_req, spnd_req, spnd_ack;
  logic        ring_load;
  logic [3:0]  ring_tx_len, ring_rx_len;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  pm_susp_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .sleep_pin(sleep_pin), .wake_active(wake_active), .sleep_req(sleep_req),
    .spnd_req(spnd_req), .spnd_ack(spnd_ack),
    .ring_load(ring_load), .ring_tx_len(ring_tx_len), .ring_rx_len(ring_rx_len)
  );

  // Behavioural reference model
  bit       m_en, m_mode, m_req, m_done, m_ring_ok;
  bit [3:0] m_tx, m_rx;
  int       m_rel;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_req = 0; m_done = 0; m_rel = 0;
    end else begin
      bit nd, nr, cw;
      if (ring_load) begin m_tx = ring_tx_len; m_rx = ring_rx_len; m_ring_ok = 1; end
      cw = wr_en && !wr_sel;
      if (m_rel < 2) m_rel++;
      else if (soft_rst) begin
        m_en = 0; m_mode = 0; m_req = 0; m_done = 0;
      end else begin
        nd = stop ? 1'b0 : (m_req && (m_done || spnd_ack));
        nr = stop ? 1'b0 : (cw ? wr_data[4] : m_req);
        if (cw) begin m_en = wr_data[0]; m_mode = wr_data[1]; end
        m_req = nr; m_done = nd;
      end
    end
  end

  function automatic void chk(logic [31:0] act, logic [31:0] exp, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endfunction

  // Every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && m_rel >= 2) begin
      chk({31'b0, spnd_req}, {31'b0, m_req}, "R5 spnd_req");
      chk({31'b0, wake_active}, {31'b0, m_mode & (sleep_pin | m_en)}, "R3 wake_active");
      chk({31'b0, sleep_req}, {31'b0, sleep_pin & ~m_mode}, "R4 sleep_req");
      if (!rd_sel)
        chk(rd_data, {27'b0, m_done, 2'b0, m_mode, m_en}, "R6 ctrl read");
      else if (!(stop || m_done))
        chk(rd_data, 32'h0, "R9 gated read");
      else if (m_ring_ok)
        chk(rd_data, {16'b0, m_tx, m_rx, 8'b0}, "R9 ring read");
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc(1);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic look();
    @(negedge clk); #1;
  endtask

  bit finished = 0;

  initial begin
    #(8 * 20000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; soft_rst = 0; stop = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
    rd_sel = 0; sleep_pin = 0; spnd_ack = 0; ring_load = 0;
    ring_tx_len = '0; ring_rx_len = '0;
    cyc(3);
    rst_n = 1;
    cyc(4);
    look();
    chk(rd_data, 32'h0, "R1 reset ctrl");
    chk({31'b0, spnd_req}, 32'h0, "R1 reset spnd_req");

    cyc(1);
    ring_load = 1; ring_tx_len = 4'h5; ring_rx_len = 4'hA;
    cyc(1);
    ring_load = 0; rd_sel = 1;
    look();
    chk(rd_data, 32'h0, "R9 no read while running");
    cyc(1);
    stop = 1;
    look();
    chk(rd_data, 32'h0000_5A00, "R9 read under stop");
    cyc(1);
    wr(1, 32'hFFFF_FFFF);
    look();
    chk(rd_data, 32'h0000_5A00, "R10 host write ignored");

    cyc(1);
    rd_sel = 0;
    wr(0, 32'h0000_0010);
    look();
    chk({31'b0, spnd_req}, 32'h0, "R5 request ignored under stop");
    cyc(1);
    stop = 0;

    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 2; s++) begin
          wr(0, {30'b0, m[0], e[0]});
          sleep_pin = s[0];
          look();
          chk({31'b0, wake_active}, {31'b0, m[0] & (s[0] | e[0])}, "R3 mode decode");
          chk(rd_data, {30'b0, m[0], e[0]}, "R2 readback");
          cyc(1);
        end
    sleep_pin = 0;

    wr(0, 32'h13);
    look();
    chk({31'b0, spnd_req}, 32'h1, "R5 request raised");
    cyc(3);
    look();
    chk(rd_data, 32'h3, "R6 not suspended before ack");
    cyc(1);
    spnd_ack = 1;
    cyc(1);
    look();
    chk(rd_data, 32'h13, "R6 suspended after ack");
    rd_sel = 1;
    look();
    chk(rd_data, 32'h0000_5A00, "R9 read while suspended");
    cyc(1);
    rd_sel = 0;
    wr(0, 32'h3);
    look();
    chk({31'b0, spnd_req}, 32'h0, "R7 request drops at write edge");
    chk(rd_data, 32'h13, "R7 flag still set one edge");
    look();
    chk(rd_data, 32'h3, "R7 flag cleared next edge");
    cyc(1);
    spnd_ack = 0;

    // Collision: ack rises in the cycle the clear write lands
    wr(0, 32'h13);
    cyc(2);
    spnd_ack = 1;
    wr(0, 32'h3);
    look();
    chk(rd_data, 32'h13, "R7 collision flag one cycle");
    look();
    chk(rd_data, 32'h3, "R7 collision flag cleared");
    cyc(1);
    spnd_ack = 0;

    // Stop while suspended
    wr(0, 32'h13);
    spnd_ack = 1;
    cyc(2);
    stop = 1;
    cyc(1);
    look();
    chk({31'b0, spnd_req}, 32'h0, "R8 stop drops request");
    chk(rd_data, 32'h3, "R8 stop clears flag, R2 wake bits kept");
    cyc(1);
    // Collision: stop with suspend write, ack still high
    wr(0, 32'h11);
    look();
    chk(rd_data, 32'h1, "R5 write under stop takes wake bits only");
    cyc(1);
    spnd_ack = 0;

    soft_rst = 1;
    cyc(1);
    soft_rst = 0;
    look();
    chk(rd_data, 32'h0, "R1 soft reset clears ctrl");
    rd_sel = 1;
    look();
    chk(rd_data, 32'h0000_5A00, "R10 soft reset keeps ring");
    cyc(1);

    rst_n = 0;
    cyc(2);
    rst_n = 1;
    cyc(3);
    look();
    chk(rd_data, 32'h0000_5A00, "R10 hard reset keeps ring");
    rd_sel = 0;
    look();
    chk(rd_data, 32'h0, "R1 hard reset ctrl");
    cyc(2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule